// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the eight-bit status byte of a serial flash device and owns its write-enable latch. The command decoder hands it single-cycle strobes: write enable, write disable, status write, and a vector of completion pulses, one for each modifying operation. The program/erase engine supplies a busy level. The block answers with the status byte that status reads shift out, a permission signal that the decoder must see high before it starts any modify command, and the function select for the two upper data lines.

The protection level, quad-enable and protection-lock bits are non-volatile. At reset they load from a port that stands in for the stored copy. The write-enable latch is volatile: it clears at reset and whenever a modifying operation finishes. When the lock bit is set, the protection-level field cannot be changed by a status write.

Top module: `flash_status_ctrl`

## Requirements
- R1: `status_out` has this layout: bit 0 is the busy input, bit 1 is the write-enable latch (WEL), bits 5:2 are the four protection-level bits, bit 6 is quad enable (QE), and bit 7 is the protection lock.
- R2: While synchronous `rst` is high, WEL clears and bits 7:2 load from `nv_init`, where `nv_init[5]` is the lock, `nv_init[4]` is QE and `nv_init[3:0]` is the protection level. With `nv_init` at zero, the status byte reads 0.
- R3: A `wren_stb` with `busy_in` low sets WEL in the following cycle. A `wren_stb` while `busy_in` is high is ignored.
- R4: WEL clears in the following cycle on `wrdi_stb`, on an accepted status write, or on any `cmpl_vec` bit. The `cmpl_vec` bits are: 0 page program, 1 sector erase, 2 block erase, 3 chip erase, 4 single block lock, 5 single block unlock, 6 gang lock, 7 gang unlock, 8 security register write, 9 protect-mode select write.
- R5: When a clearing event and `wren_stb` occur in the same cycle, WEL ends up 0.
- R6: A `wrsr_stb` is accepted only when WEL is 1 and `busy_in` is 0. A rejected attempt leaves all status bits unchanged, including WEL.
- R7: An accepted status write takes bits 7:2 of `wr_data` into lock, QE and protection level in the next cycle. It ignores `wr_data[1:0]`.
- R8: While the lock bit currently reads 1, an accepted status write leaves the protection level unchanged. QE and the lock bit stay writable.
- R9: `modify_ok` is high exactly when WEL is 1 and `busy_in` is 0.
- R10: Both `upper_io_quad` bits are 1, meaning the lines act as quad data, when QE is 1 or `qpi_mode` is 1. Otherwise both are 0, meaning the lines act as write-protect and hold inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| nv_init | input | 6 | Stored values of the non-volatile bits: {lock, QE, level[3:0]} |
| wren_stb | input | 1 | Write-enable instruction strobe |
| wrdi_stb | input | 1 | Write-disable instruction strobe |
| wrsr_stb | input | 1 | Status-write instruction strobe |
| wr_data | input | 8 | Byte carried by the status write |
| cmpl_vec | input | CMPL_N | Completion pulses of the modifying operations |
| busy_in | input | 1 | Program/erase engine in progress |
| qpi_mode | input | 1 | Device operates in four-line command mode |
| status_out | output | 8 | Status byte for reads |
| modify_ok | output | 1 | Modify commands may start |
| upper_io_quad | output | 2 | Lines 2 and 3 act as quad data |

## Verification
The bench pulses each of the ten completion bits on its own and checks that each one clears WEL; a design that left a bit out of the clear term would keep write permission after that operation. It drives a write-enable together with a chip-erase completion in the same cycle; a design with the wrong priority would come out of the erase still write-enabled. It tries status writes with WEL low and with the engine busy; a design that skips either gate would change protection bits or drop WEL. It sets the lock with one write and changes the level in a later write, then clears the lock; a design that gated on the incoming data instead of the stored lock, or that locked QE as well, would give a different byte.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

    localparam int STATUS_W = 8;
    localparam int LEVEL_W  = 4;
    localparam int NV_W     = LEVEL_W + 2;

    // Completion vector bit positions
    localparam int C_PAGE_PROG  = 0;
    localparam int C_SECT_ERASE = 1;
    localparam int C_BLK_ERASE  = 2;
    localparam int C_CHIP_ERASE = 3;
    localparam int C_ONE_LOCK   = 4;
    localparam int C_ONE_UNLOCK = 5;
    localparam int C_ALL_LOCK   = 6;
    localparam int C_ALL_UNLOCK = 7;
    localparam int C_SEC_WRITE  = 8;
    localparam int C_PMODE_WR   = 9;
    localparam int CMPL_DEF     = 10;

    typedef struct packed {
        logic               lock;
        logic               qe;
        logic [LEVEL_W-1:0] level;
    } nv_bits_t;

    typedef struct packed {
        nv_bits_t nv;
        logic     wel;
        logic     busy;
    } status_t;

    function automatic status_t build_status(nv_bits_t nv, logic wel, logic busy);
        status_t s;
        s.nv   = nv;
        s.wel  = wel;
        s.busy = busy;
        return s;
    endfunction

    // Merge a status-write byte into the current non-volatile bits
    function automatic nv_bits_t merge_write(nv_bits_t cur, logic [STATUS_W-1:0] data);
        status_t  incoming;
        nv_bits_t nxt;
        incoming  = status_t'(data);
        nxt.lock  = incoming.nv.lock;
        nxt.qe    = incoming.nv.qe;
        nxt.level = cur.lock ? cur.level : incoming.nv.level;
        return nxt;
    endfunction

endpackage

// File: rtl/flsr_wel_latch.sv
module flsr_wel_latch
    import flsr_pkg::*;
#(
    parameter int CMPL_N = CMPL_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_stb,
    input  logic              wrdi_stb,
    input  logic              wrsr_ok,
    input  logic [CMPL_N-1:0] cmpl_vec,
    input  logic              busy_in,
    output logic              wel
);

    logic clear_req;
    logic set_req;

    assign clear_req = wrdi_stb | wrsr_ok | (|cmpl_vec);
    assign set_req   = wren_stb & ~busy_in;

    always_ff @(posedge clk) begin
        if (rst)
            wel <= 1'b0;
        else if (clear_req)
            wel <= 1'b0;
        else if (set_req)
            wel <= 1'b1;
    end

    // R4
    cmpl_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (|cmpl_vec) |=> !wel);

    // R5
    clear_beats_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wren_stb && (wrdi_stb || (|cmpl_vec))) |=> !wel);

    // R3
    wren_sets_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (wren_stb && !busy_in && !wrdi_stb && !wrsr_ok && !(|cmpl_vec)) |=> wel);

    // R3
    busy_blocks_wren_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_in && !wel) |=> !wel);

endmodule

// File: rtl/flsr_nv_reg.sv
module flsr_nv_reg
    import flsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NV_W-1:0]     nv_init,
    input  logic                wr_en,
    input  logic [STATUS_W-1:0] wr_data,
    output nv_bits_t            nv_q
);

    always_ff @(posedge clk) begin
        if (rst)
            nv_q <= nv_bits_t'(nv_init);
        else if (wr_en)
            nv_q <= merge_write(nv_q, wr_data);
    end

    // R8
    lock_holds_level_chk: assert property (@(posedge clk) disable iff (rst)
        nv_q.lock |=> $stable(nv_q.level));

    // R7
    write_takes_qe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (nv_q.qe == $past(wr_data[6])) && (nv_q.lock == $past(wr_data[7])));

endmodule

// File: rtl/flsr_pin_sel.sv
module flsr_pin_sel #(
    parameter int LANES = 2
) (
    input  logic             qe,
    input  logic             qpi_mode,
    output logic [LANES-1:0] quad_sel
);

    logic quad_any;
    assign quad_any = qe | qpi_mode;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign quad_sel[g] = quad_any;
    end

    // R10
    always_comb begin
        qpi_forces_quad_chk: assert (!qpi_mode || (&quad_sel));
    end

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import flsr_pkg::*;
#(
    parameter int CMPL_N = CMPL_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NV_W-1:0]     nv_init,
    input  logic                wren_stb,
    input  logic                wrdi_stb,
    input  logic                wrsr_stb,
    input  logic [STATUS_W-1:0] wr_data,
    input  logic [CMPL_N-1:0]   cmpl_vec,
    input  logic                busy_in,
    input  logic                qpi_mode,
    output logic [STATUS_W-1:0] status_out,
    output logic                modify_ok,
    output logic [1:0]          upper_io_quad
);

    logic     wel;
    logic     wrsr_ok;
    nv_bits_t nv_q;
    status_t  stat;

    assign wrsr_ok = wrsr_stb & wel & ~busy_in;

    flsr_wel_latch #(.CMPL_N(CMPL_N)) u_wel (
        .clk      (clk),
        .rst      (rst),
        .wren_stb (wren_stb),
        .wrdi_stb (wrdi_stb),
        .wrsr_ok  (wrsr_ok),
        .cmpl_vec (cmpl_vec),
        .busy_in  (busy_in),
        .wel      (wel)
    );

    flsr_nv_reg u_nv (
        .clk     (clk),
        .rst     (rst),
        .nv_init (nv_init),
        .wr_en   (wrsr_ok),
        .wr_data (wr_data),
        .nv_q    (nv_q)
    );

    flsr_pin_sel #(.LANES(2)) u_pins (
        .qe       (nv_q.qe),
        .qpi_mode (qpi_mode),
        .quad_sel (upper_io_quad)
    );

    assign stat       = build_status(nv_q, wel, busy_in);
    assign status_out = stat;
    assign modify_ok  = wel & ~busy_in;

    // R6
    rejected_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wrsr_stb && !(status_out[1] && !busy_in)) |=> $stable(status_out[7:2]));

    // R9
    busy_denies_modify_chk: assert property (@(posedge clk) disable iff (rst)
        busy_in |-> !modify_ok);

endmodule

// File: tb/flash_status_ctrl_tb.sv
module flash_status_ctrl_tb;

    localparam int CLK_P  = 10;
    localparam int NCMPL  = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic [5:0]       nv_init;
    logic             wren_stb, wrdi_stb, wrsr_stb;
    logic [7:0]       wr_data;
    logic [NCMPL-1:0] cmpl_vec;
    logic             busy_in, qpi_mode;
    logic [7:0]       status_out;
    logic             modify_ok;
    logic [1:0]       upper_io_quad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_status_ctrl #(.CMPL_N(NCMPL)) u_dut (
        .clk(clk), .rst(rst), .nv_init(nv_init),
        .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb),
        .wr_data(wr_data), .cmpl_vec(cmpl_vec), .busy_in(busy_in),
        .qpi_mode(qpi_mode), .status_out(status_out), .modify_ok(modify_ok),
        .upper_io_quad(upper_io_quad)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, sample 1 unit after it
    task automatic step();
        @(posedge clk);
        #1;
        wren_stb = 0; wrdi_stb = 0; wrsr_stb = 0; cmpl_vec = '0;
        @(negedge clk);
    endtask

    task automatic do_wren();
        wren_stb = 1; step();
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data = d; wrsr_stb = 1; step();
    endtask

    task automatic t_reset();
        nv_init = 6'h00; rst = 1; step(); step(); rst = 0;
        chk("R2 zero reset", status_out, 8'h00);
        nv_init = 6'b011010; rst = 1; step(); rst = 0;
        chk("R2 nv load", status_out, 8'h68);
        chk("R10 qe from load", {6'b0, upper_io_quad}, 8'h03);
        nv_init = 6'h00; rst = 1; step(); rst = 0;
        chk("R2 reload zero", status_out, 8'h00);
    endtask

    task automatic t_layout_wren();
        busy_in = 1; #1;
        chk("R1 busy bit", status_out, 8'h01);
        do_wren();
        chk("R3 wren ignored busy", status_out, 8'h01);
        busy_in = 0; #1;
        do_wren();
        chk("R3 wren sets", status_out, 8'h02);
        chk("R9 modify ok", {7'b0, modify_ok}, 8'h01);
        busy_in = 1; #1;
        chk("R9 busy denies", {7'b0, modify_ok}, 8'h00);
        chk("R1 busy+wel", status_out, 8'h03);
        busy_in = 0; #1;
    endtask

    task automatic t_clears();
        for (int i = 0; i < NCMPL; i++) begin
            do_wren();
            cmpl_vec = NCMPL'(1) << i; step();
            chk($sformatf("R4 cmpl bit %0d", i), status_out, 8'h00);
        end
        do_wren();
        wrdi_stb = 1; step();
        chk("R4 wrdi clears", status_out, 8'h00);
        wren_stb = 1; cmpl_vec[3] = 1; step();
        chk("R5 priority from 0", status_out, 8'h00);
        do_wren();
        wren_stb = 1; wrdi_stb = 1; step();
        chk("R5 priority from 1", status_out, 8'h00);
    endtask

    task automatic t_writes();
        do_write(8'hFC);
        chk("R6 rejected wel0", status_out, 8'h00);
        do_wren();
        do_write(8'h3F);
        chk("R7 accept ignore low", status_out, 8'h3C);
        do_write(8'hC0);
        chk("R6 rejected after clear", status_out, 8'h3C);
        do_wren();
        busy_in = 1; #1;
        do_write(8'h00);
        chk("R6 rejected busy", status_out, 8'h3F);
        busy_in = 0; #1;
        chk("R6 wel kept", status_out, 8'h3E);
    endtask

    task automatic t_lock();
        do_wren(); do_write(8'h80);
        chk("R8 set lock", status_out, 8'h80);
        do_wren(); do_write(8'hFC);
        chk("R8 level frozen qe set", status_out, 8'hC0);
        chk("R10 qe quad", {6'b0, upper_io_quad}, 8'h03);
        do_wren(); do_write(8'h04);
        chk("R8 unlock level held", status_out, 8'h00);
        do_wren(); do_write(8'h04);
        chk("R8 level writable", status_out, 8'h04);
    endtask

    task automatic t_pins();
        chk("R10 spi pins", {6'b0, upper_io_quad}, 8'h00);
        qpi_mode = 1; #1;
        chk("R10 qpi forces quad", {6'b0, upper_io_quad}, 8'h03);
        qpi_mode = 0; #1;
    endtask

    initial begin
        rst = 1; nv_init = 0; wren_stb = 0; wrdi_stb = 0; wrsr_stb = 0;
        wr_data = 0; cmpl_vec = '0; busy_in = 0; qpi_mode = 0;
        @(negedge clk);
        t_reset();
        t_layout_wren();
        t_clears();
        t_writes();
        t_lock();
        t_pins();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule